// File: doc/BRIEF.md
# SPI Pseudo-Random Byte Source

This block gives a host a stream of pseudo-random bytes over a plain SPI target port. Inside, a 16-bit linear-feedback shift register advances once on every system clock. The host never writes to the block. Each 8-bit frame returns the upper byte of the generator state, captured at the moment the frame begins to shift out.

A 16-bit seed bus is sampled once, when chip-select is first driven low after reset. The seed is copied into the generator, and from then on every later frame reads the same seeded sequence. Later chip-select assertions never reseed the generator. A zero seed would trap the register in its all-zero state, so the block substitutes the reset constant in that case.

SCLK and chip-select are brought into the system-clock domain through two-flop synchronizers, so SCLK must run no faster than a quarter of the system clock. The port works in the mode with SCLK idling high. MISO changes after each falling SCLK edge, and the host samples it on the rising edge. Data on MOSI is never looked at.

Top module: `prng_spi_source`

## Requirements
- R1: On every system clock outside the seed-load cycle, the state shifts left by one. Bit 15 is dropped, and bit 0 takes the XOR of state bits 15, 13, 12 and 10 (zero-based). After reset the state is 16'hACE1.
- R2: On the first assertion of chip-select (low) after reset, the value on seed_in is copied into the state once, so that later frames follow the sequence that starts at that seed.
- R3: Chip-select assertions after the first one never reload the seed, even if seed_in has changed.
- R4: If seed_in is 16'h0000 when the seed is taken, the state is loaded with 16'hACE1.
- R5: A frame is 8 bits, sent MSB first. At the first falling SCLK edge with chip-select low, MISO takes bit 7 of the transmit byte, and each following falling edge presents the next lower bit. The transmit byte is state[15:8], captured just before that first falling edge.
- R6: While chip-select is high, MISO is driven 0.
- R7: Deasserting chip-select clears the bit counter, so a frame cut short leaves the next frame starting again at bit 7 with a freshly captured byte.
- R8: The value on spi_mosi has no effect on the bytes returned.
- R9: Once the first bit of a frame has been presented, the transmit byte stays unchanged until the bit counter returns to zero.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spi_cs_n | input | 1 | SPI chip-select, active low, asynchronous to clk |
| spi_sclk | input | 1 | SPI serial clock, idles high, at most clk/4 |
| spi_mosi | input | 1 | SPI data from host, ignored |
| spi_miso | output | 1 | SPI data to host, registered |
| seed_in | input | 16 | Seed taken on the first chip-select after reset |

## Verification
The hardest case to reach from the ports is a byte that must be tied to the exact generator step at which it was captured. That step depends on synchronizer latency and on a generator that never stops. The bench keeps its own model of the sequence starting from the seed, and counts clocks from the first chip-select. It then accepts a byte only if it matches the high byte of the model at a step inside a short window after the frame start. A frame cut short after three bits, followed by a reseed attempt with a different seed, drives the counter-clear path and the one-time seed path.

// File: rtl/prng_spi_pkg.sv
package prng_spi_pkg;

    localparam int LFSR_W = 16;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int SYNC_STAGES = 2;

    localparam logic [LFSR_W-1:0] LFSR_INIT = 16'hACE1;
    // feedback taps at bits 15, 13, 12, 10
    localparam logic [LFSR_W-1:0] TAP_MASK  = 16'hB400;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  bitcnt_t;

    typedef struct packed {
        logic cs_act;     // chip-select asserted, synchronized
        logic sclk_rise;  // one-cycle pulse on rising SCLK
        logic sclk_fall;  // one-cycle pulse on falling SCLK
    } spi_evt_t;

    function automatic lfsr_t lfsr_step(input lfsr_t s);
        return {s[LFSR_W-2:0], ^(s & TAP_MASK)};
    endfunction

    function automatic lfsr_t seed_fix(input lfsr_t s);
        return (s == '0) ? LFSR_INIT : s;
    endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync
    import prng_spi_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sclk_raw,
    input  logic     cs_n_raw,
    output spi_evt_t evt
);
    // one extra stage beyond the synchronizer holds the previous value
    logic [STAGES:0] sclk_pipe;
    logic [STAGES:0] cs_pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_pipe <= '1;
            cs_pipe   <= '1;
        end else begin
            sclk_pipe <= {sclk_pipe[STAGES-1:0], sclk_raw};
            cs_pipe   <= {cs_pipe[STAGES-1:0], cs_n_raw};
        end
    end

    always_comb begin
        evt.cs_act    = !cs_pipe[STAGES-1];
        evt.sclk_rise =  sclk_pipe[STAGES-1] && !sclk_pipe[STAGES];
        evt.sclk_fall = !sclk_pipe[STAGES-1] &&  sclk_pipe[STAGES];
    end

endmodule

// File: rtl/prng_lfsr_core.sv
module prng_lfsr_core
    import prng_spi_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs_act,
    input  lfsr_t seed,
    output lfsr_t state,
    output logic  seeded
);
    logic load_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seeded <= 1'b0;
            load_q <= 1'b0;
            state  <= LFSR_INIT;
        end else begin
            load_q <= !seeded && cs_act;
            if (!seeded && cs_act)
                seeded <= 1'b1;
            state <= load_q ? seed_fix(seed) : lfsr_step(state);
        end
    end

    AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |=> !load_q && seeded);  // R3

    AST_STATE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);  // R4

endmodule

// File: rtl/spi_byte_tx.sv
module spi_byte_tx
    import prng_spi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  spi_evt_t evt,
    input  logic     seeded,
    input  byte_t    snap,
    output logic     miso
);
    bitcnt_t cnt;
    byte_t   tx_byte;
    logic    hold;
    logic    reload;

    assign reload = (cnt == '0) && seeded && !hold && !(evt.cs_act && evt.sclk_fall);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            hold    <= 1'b0;
            miso    <= 1'b0;
            tx_byte <= '0;
        end else begin
            if (reload)
                tx_byte <= snap;
            if (!evt.cs_act) begin
                cnt  <= '0;
                hold <= 1'b0;
                miso <= 1'b0;
            end else begin
                if (evt.sclk_rise) begin
                    cnt  <= cnt + 1'b1;
                    hold <= 1'b0;
                end
                if (evt.sclk_fall) begin
                    miso <= tx_byte[CNT_W'(BYTE_W-1) - cnt];
                    if (cnt == '0)
                        hold <= 1'b1;
                end
            end
        end
    end

    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !evt.cs_act |=> !miso);  // R6

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !evt.cs_act |=> cnt == '0);  // R7

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> $stable(tx_byte));  // R9

endmodule

// File: rtl/prng_spi_source.sv
module prng_spi_source
    import prng_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [LFSR_W-1:0] seed_in
);
    spi_evt_t evt;
    lfsr_t    state;
    logic     seeded;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_raw (spi_sclk),
        .cs_n_raw (spi_cs_n),
        .evt      (evt)
    );

    prng_lfsr_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_act (evt.cs_act),
        .seed   (seed_in),
        .state  (state),
        .seeded (seeded)
    );

    spi_byte_tx u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .seeded (seeded),
        .snap   (state[LFSR_W-1 -: BYTE_W]),
        .miso   (spi_miso)
    );

    AST_SEED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seeded |=> seeded);  // R2

endmodule

// File: tb/prng_spi_source_bench.sv
module prng_spi_source_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 4;
    localparam int WIN        = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [15:0] seed = 16'h0000;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int c_seed = 0;
    bit done   = 1'b0;
    logic [15:0] model_seed;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    prng_spi_source u_prng_spi_source (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_cs_n (cs_n),
        .spi_sclk (sclk),
        .spi_mosi (mosi),
        .spi_miso (miso),
        .seed_in  (seed)
    );

    function automatic logic [15:0] step16(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // does b equal the high byte of the model at a step in [d, d+WIN]?
    function automatic bit in_window(input logic [15:0] s0, input int d, input logic [7:0] b);
        logic [15:0] s = s0;
        for (int j = 0; j <= d + WIN; j++) begin
            if (j >= d && s[15:8] == b) return 1'b1;
            s = step16(s);
        end
        return 1'b0;
    endfunction

    function automatic logic [7:0] hi_at(input logic [15:0] s0, input int d);
        logic [15:0] s = s0;
        for (int j = 0; j < d; j++) s = step16(s);
        return s[15:8];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cs_n = 1'b1;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // shift nbits of a frame; the host samples just before each rising SCLK
    task automatic frame(input int nbits, input bit wiggle, output logic [7:0] b, output int cf);
        b = '0;
        @(negedge clk);
        cs_n = 1'b0;
        cf = cyc;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            if (wiggle) mosi = ~mosi;
            repeat (HALF_SCLK) @(negedge clk);
            b = {b[6:0], miso};
            sclk = 1'b1;
            repeat (HALF_SCLK) @(negedge clk);
        end
        repeat (HALF_SCLK) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_frame(input string req, input bit wiggle);
        logic [7:0] b;
        int cf;
        frame(8, wiggle, b, cf);
        chk(in_window(model_seed, cf - c_seed, b), req, {8'h0, b},
            {8'h0, hi_at(model_seed, cf - c_seed + 6)});
    endtask

    task automatic test_reset_idle();
        do_reset();
        chk(miso === 1'b0, "R6 idle after reset", {15'h0, miso}, 16'h0);
    endtask

    task automatic test_seed_load();
        logic [7:0] b;
        int cf;
        seed = 16'h1234;
        model_seed = 16'h1234;
        do_reset();
        frame(8, 1'b0, b, cf);
        c_seed = cf;
        chk(in_window(model_seed, 0, b), "R2 first frame from seed", {8'h0, b},
            {8'h0, hi_at(model_seed, 6)});
        check_frame("R1 sequence frame 2", 1'b0);
        check_frame("R5 sequence frame 3", 1'b0);
        chk(miso === 1'b0, "R6 idle after frame", {15'h0, miso}, 16'h0);
    endtask

    task automatic test_no_reseed();
        seed = 16'hBEEF;
        check_frame("R3 no reseed frame 1", 1'b0);
        check_frame("R3 no reseed frame 2", 1'b0);
    endtask

    task automatic test_zero_seed();
        logic [7:0] b;
        int cf;
        seed = 16'h0000;
        model_seed = 16'hACE1;
        do_reset();
        frame(8, 1'b0, b, cf);
        c_seed = cf;
        chk(in_window(model_seed, 0, b), "R4 zero seed substituted", {8'h0, b},
            {8'h0, hi_at(model_seed, 6)});
        check_frame("R4 zero seed frame 2", 1'b0);
    endtask

    task automatic test_partial_frame();
        logic [7:0] b;
        int cf;
        frame(3, 1'b0, b, cf);
        chk(miso === 1'b0, "R6 idle after short frame", {15'h0, miso}, 16'h0);
        check_frame("R7 frame after short frame", 1'b0);
        frame(5, 1'b0, b, cf);
        check_frame("R7 frame after five-bit frame", 1'b0);
    endtask

    task automatic test_mosi_ignored();
        mosi = 1'b1;
        check_frame("R8 mosi toggling", 1'b1);
        mosi = 1'b0;
        check_frame("R9 held byte with mosi low", 1'b0);
        mosi = 1'b1;
        check_frame("R8 mosi high", 1'b0);
    endtask

    initial begin
        test_reset_idle();
        test_seed_load();
        test_no_reseed();
        test_partial_frame();
        test_mosi_ignored();
        test_zero_seed();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule